// File: doc/BRIEF.md
# Pixel Unpacker with Palette Lookup

The block turns a stream of 32-bit display words into one RGB pixel per advance request. A word is taken from a display FIFO over a valid/ready handshake and held until every pixel packed in it has been emitted. The number of pixels per word follows the programmed pixel depth: 32, 16, 8, 4, 2 or 1.

At 1, 2, 4 and 8 bits per pixel the unpacked value is an index into a 256-entry colour palette. At 16 and 24 bits per pixel it is used directly as colour. The palette is 128 words of 32 bits, each word holding two 16-bit entries. A host port reads and writes whole palette words, and the pixel path reads the palette through its own port. Mode inputs set the pixel depth, the byte order within the word, the pixel order within a byte, and an optional red/blue swap. Mode inputs are expected to change only between words.

Top module: `pix_unpack`

## Requirements
- R1: After reset, pix_valid and underflow are 0 and word_ready is 1, so no word is held.
- R2: bpp_sel selects the depth: 0=1, 1=2, 2=4, 3=8, 4=16, and 5 to 7 = 24 bits per pixel. A held word yields 32, 16, 8, 4, 2 or 1 pixels respectively. word_ready is 0 while a word is held, except during the advance that emits its last pixel.
- R3: At 1 to 8 bpp the pixel value i addresses the palette. Entry i is the low halfword of palette word i/2 when i is even and the high halfword when i is odd. An entry holds R in [4:0], G in [9:5] and B in [14:10]; bit 15 is unused. Each 5-bit component c is widened to {c, c[4:2]}.
- R4: At 16 bpp, halfword n of the byte-ordered word (bits [16n+15:16n]) is pixel n. It is decoded with the same 5-5-5 layout and widening as a palette entry, and its bit 15 is ignored.
- R5: At 24 bpp each word is one pixel, with R in byte 0, G in byte 1 and B in byte 2 of the byte-ordered word. Byte 3 is ignored.
- R6: With byte_be=0, byte k of the word is bits [8k+7:8k]. With byte_be=1, byte k is bits [31-8k:24-8k]. Pixels are taken from byte 0 upward.
- R7: At 1, 2 and 4 bpp with pix_be=0, pixel j of a byte sits at bit offset w*j, where w is the depth. With pix_be=1 it sits at offset 8-w*(j+1). pix_be has no effect at 8 bpp or above.
- R8: With swap_rb=1 the red and blue bytes of pix_rgb trade places. pix_rgb is {R,G,B} with R in bits [23:16].
- R9: A pix_adv while a word is held gives pix_valid=1 with the pixel in the following cycle. In every other cycle pix_valid is 0.
- R10: A pix_adv while no word is held raises underflow for one cycle, one cycle later, with pix_valid low.
- R11: A host access with host_en=1 writes host_wdata to palette word host_addr when host_we=1. Every access returns the addressed word's prior contents on host_rdata in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_in | input | 32 | FIFO data word |
| word_valid | input | 1 | FIFO word available |
| word_ready | output | 1 | Block accepts the word this cycle |
| bpp_sel | input | 3 | Pixel depth code |
| byte_be | input | 1 | Big-endian byte order within the word |
| pix_be | input | 1 | Big-endian pixel order within a byte |
| swap_rb | input | 1 | Exchange red and blue outputs |
| pix_adv | input | 1 | Request the next pixel |
| pix_valid | output | 1 | pix_rgb carries a pixel |
| pix_rgb | output | 24 | Pixel colour {R,G,B} |
| underflow | output | 1 | A pixel was requested with no word held |
| host_en | input | 1 | Host palette access |
| host_we | input | 1 | Host access is a write |
| host_addr | input | 7 | Palette word address |
| host_wdata | input | 32 | Palette write data |
| host_rdata | output | 32 | Palette read data |

## Verification
The assertions assume that the mode inputs stay constant while a word is held. They also assume the host never writes a palette word in the same cycle that the pixel path reads it, since that read returns the old contents. The stimulus meets both conditions. It changes mode only after the last pixel of a word has been drawn, and it loads the palette completely before any pixel is requested. Underflow is provoked only by advancing with no word loaded. Every word is presented with pix_adv low, so the acceptance cycle is deterministic.

// File: rtl/pix_unpack.sv
module pix_unpack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] word_in,
  input  logic        word_valid,
  output logic        word_ready,
  input  logic [2:0]  bpp_sel,
  input  logic        byte_be,
  input  logic        pix_be,
  input  logic        swap_rb,
  input  logic        pix_adv,
  output logic        pix_valid,
  output logic [23:0] pix_rgb,
  output logic        underflow,
  input  logic        host_en,
  input  logic        host_we,
  input  logic [6:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata
);
  localparam int IDX_W     = 8;
  localparam int HA_W      = IDX_W - 1;
  localparam int PAL_WORDS = 2 ** HA_W;
  localparam logic [1:0] K_PAL = 2'd0, K_T16 = 2'd1, K_T24 = 2'd2;

  logic [31:0] pal [PAL_WORDS];
  logic [31:0] pal_q, hold_w, nw, shifted;
  logic        held, last, step;
  logic [4:0]  pidx, ppw_m1, off, pos;
  logic [2:0]  wid3, inb;
  logic [7:0]  mask, pidx_val;
  logic [1:0]  s_kind;
  logic        s_hi, s_swap;
  logic [23:0] s_raw;
  logic [15:0] ent;
  logic [7:0]  r8, g8, b8;

  assign nw = byte_be ? {hold_w[7:0], hold_w[15:8], hold_w[23:16], hold_w[31:24]} : hold_w;

  always_comb begin
    case (bpp_sel)
      3'd0: ppw_m1 = 5'd31;
      3'd1: ppw_m1 = 5'd15;
      3'd2: ppw_m1 = 5'd7;
      3'd3: ppw_m1 = 5'd3;
      3'd4: ppw_m1 = 5'd1;
      default: ppw_m1 = 5'd0;
    endcase
    if (bpp_sel < 3'd4)       off = 5'(pidx << bpp_sel[1:0]);
    else if (bpp_sel == 3'd4) off = {pidx[0], 4'b0};
    else                      off = 5'd0;
  end

  assign wid3     = 3'(4'd1 << bpp_sel[1:0]);
  assign inb      = (pix_be && bpp_sel < 3'd3) ? 3'(3'd0 - wid3 - off[2:0]) : off[2:0];
  assign pos      = {off[4:3], inb};
  assign shifted  = nw >> pos;
  assign mask     = 8'((9'd1 << (4'd1 << bpp_sel[1:0])) - 9'd1);
  assign pidx_val = shifted[7:0] & mask;
  assign last     = pidx == ppw_m1;
  assign step     = pix_adv && held;
  assign word_ready = !held || (pix_adv && last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0; pidx <= '0; hold_w <= '0;
      pix_valid <= 1'b0; underflow <= 1'b0;
      s_kind <= K_PAL; s_hi <= 1'b0; s_swap <= 1'b0; s_raw <= '0;
    end else begin
      pix_valid <= step;
      underflow <= pix_adv && !held;
      if (step) begin
        s_kind <= (bpp_sel < 3'd4) ? K_PAL : (bpp_sel == 3'd4) ? K_T16 : K_T24;
        s_hi   <= pidx_val[0];
        s_swap <= swap_rb;
        s_raw  <= (bpp_sel == 3'd4) ? {8'd0, shifted[15:0]} : nw[23:0];
        pidx   <= last ? 5'd0 : pidx + 5'd1;
        if (last) held <= 1'b0;
      end
      if (word_valid && word_ready) begin
        hold_w <= word_in;
        held   <= 1'b1;
        pidx   <= 5'd0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (step) pal_q <= pal[pidx_val[IDX_W-1:1]];
  end

  always_ff @(posedge clk) begin
    if (host_en) begin
      if (host_we) pal[host_addr] <= host_wdata;
      host_rdata <= pal[host_addr];
    end
  end

  assign ent = (s_kind == K_PAL) ? (s_hi ? pal_q[31:16] : pal_q[15:0]) : s_raw[15:0];

  always_comb begin
    if (s_kind == K_T24) begin
      r8 = s_raw[7:0]; g8 = s_raw[15:8]; b8 = s_raw[23:16];
    end else begin
      r8 = {ent[4:0],   ent[4:2]};
      g8 = {ent[9:5],   ent[9:7]};
      b8 = {ent[14:10], ent[14:12]};
    end
  end

  assign pix_rgb = s_swap ? {b8, g8, r8} : {r8, g8, b8};

  p_adv_gives_pixel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_adv && held |=> pix_valid && !underflow);
  p_idle_no_pixel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_adv |=> !pix_valid && !underflow);
  p_empty_adv_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_adv && !held |=> underflow && !pix_valid);
  p_accept_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && word_ready |=> held);
  p_word_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    held && !pix_adv |=> held && $stable(hold_w));
  p_single_pixel_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bpp_sel >= 3'd5 && pix_adv && held |-> word_ready);
endmodule

// File: tb/pix_unpack_bench.sv
module pix_unpack_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [31:0] word_in = 0;
  logic word_valid = 0, word_ready;
  logic [2:0] bpp_sel = 0;
  logic byte_be = 0, pix_be = 0, swap_rb = 0, pix_adv = 0;
  logic pix_valid, underflow;
  logic [23:0] pix_rgb;
  logic host_en = 0, host_we = 0;
  logic [6:0] host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_unpack u_pix_unpack (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] entry(int i);
    return 16'((i * 16'h0123) ^ 16'h5a5a);
  endfunction

  function automatic logic [23:0] to_rgb(logic [15:0] e, logic sw);
    logic [7:0] r, g, b;
    r = {e[4:0], e[4:2]}; g = {e[9:5], e[9:7]}; b = {e[14:10], e[14:12]};
    return sw ? {b, g, r} : {r, g, b};
  endfunction

  function automatic logic [7:0] byte_of(logic [31:0] w, int k, logic be);
    return be ? w[8*(3-k) +: 8] : w[8*k +: 8];
  endfunction

  function automatic int ppw(int code);
    return (code >= 5) ? 1 : 32 >> code;
  endfunction

  function automatic logic [23:0] model(logic [31:0] w, int code, int i, logic be, logic pbe, logic sw);
    if (code <= 3) begin
      int wd = 1 << code;
      int n = 8 / wd;
      int j = i % n;
      int sh = (pbe && code < 3) ? 8 - wd * (j + 1) : wd * j;
      int idx = (int'(byte_of(w, i / n, be)) >> sh) & ((1 << wd) - 1);
      return to_rgb(entry(idx), sw);
    end else if (code == 4) begin
      return to_rgb({byte_of(w, 2*i+1, be), byte_of(w, 2*i, be)}, sw);
    end else begin
      logic [7:0] r, g, b;
      r = byte_of(w, 0, be); g = byte_of(w, 1, be); b = byte_of(w, 2, be);
      return sw ? {b, g, r} : {r, g, b};
    end
  endfunction

  task automatic host_write(int a, logic [31:0] d);
    @(negedge clk); host_en = 1; host_we = 1; host_addr = 7'(a); host_wdata = d;
    @(negedge clk); host_en = 0; host_we = 0;
  endtask

  task automatic t_reset;
    chk("R1 word_ready", 32'(word_ready), 1);
    chk("R1 pix_valid", 32'(pix_valid), 0);
    chk("R1 underflow", 32'(underflow), 0);
  endtask

  task automatic t_mode(string req, int code, logic [31:0] w, logic be, logic pbe, logic sw);
    int n = ppw(code);
    @(negedge clk);
    bpp_sel = 3'(code); byte_be = be; pix_be = pbe; swap_rb = sw;
    word_in = w; word_valid = 1;
    @(negedge clk); word_valid = 0;
    chk({req, " R2 held ready"}, 32'(word_ready), 0);
    for (int i = 0; i < n; i++) begin
      pix_adv = 1;
      #1 chk({req, " R2 ready at last"}, 32'(word_ready), (i == n-1) ? 1 : 0);
      @(negedge clk); pix_adv = 0;
      chk({req, " R9 valid"}, 32'(pix_valid), 1);
      chk({req, " pixel"}, 32'(pix_rgb), 32'(model(w, code, i, be, pbe, sw)));
    end
    @(negedge clk);
    chk({req, " R9 idle"}, 32'(pix_valid), 0);
    chk({req, " R2 released"}, 32'(word_ready), 1);
  endtask

  task automatic t_underflow;
    @(negedge clk); pix_adv = 1;
    @(negedge clk); pix_adv = 0;
    chk("R10 underflow", 32'(underflow), 1);
    chk("R10 no pixel", 32'(pix_valid), 0);
    @(negedge clk);
    chk("R10 one cycle", 32'(underflow), 0);
  endtask

  task automatic t_host;
    @(negedge clk); host_en = 1; host_we = 0; host_addr = 7'd5;
    @(negedge clk); host_en = 0;
    chk("R11 read", host_rdata, {entry(11), entry(10)});
    host_write(127, 32'hcafe_f00d);
    @(negedge clk); host_en = 1; host_addr = 7'd127;
    @(negedge clk); host_en = 0;
    chk("R11 write-read", host_rdata, 32'hcafe_f00d);
    host_write(127, {entry(255), entry(254)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    for (int k = 0; k < 128; k++) host_write(k, {entry(2*k+1), entry(2*k)});
    t_host();
    t_mode("R3 R2 1bpp", 0, 32'h9c3a_5e71, 0, 0, 0);
    t_mode("R7 1bpp pix_be", 0, 32'h9c3a_5e71, 0, 1, 0);
    t_mode("R6 2bpp byte_be", 1, 32'h1b2d_e4c7, 1, 0, 0);
    t_mode("R7 R6 4bpp both", 2, 32'h0f1e_2d3c, 1, 1, 0);
    t_mode("R3 8bpp", 3, 32'hfe01_8055, 0, 0, 0);
    t_mode("R7 8bpp pix_be no effect", 3, 32'hfe01_8055, 0, 1, 0);
    t_mode("R8 8bpp swap", 3, 32'h7f3c_a2d9, 0, 0, 1);
    t_mode("R4 16bpp", 4, 32'hfbcd_7531, 0, 0, 0);
    t_mode("R4 R6 16bpp byte_be", 4, 32'hfbcd_7531, 1, 0, 0);
    t_mode("R5 24bpp", 5, 32'hff12_3456, 0, 0, 0);
    t_mode("R5 R8 24bpp swap", 7, 32'h00a1_b2c3, 0, 0, 1);
    t_mode("R5 R6 24bpp byte_be", 6, 32'h1122_33ee, 1, 0, 0);
    t_underflow();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule